// File: doc/BRIEF.md
# Per-Rank ODT Mask Driver

This block drives the four on-die-termination pins of a multi-rank DRAM channel while a write or read burst is in flight. Two mask registers are kept: one for writes and one for reads. Each holds one field per rank position. When a command is accepted for a rank, the block looks up that rank's field in the register for the command's direction. It drives the pins with that field for the length of the termination window, then returns them to zero. A rank's own pin may never be asserted during a read from that rank. When the read field asks for it, the block clears that bit and raises a violation flag for the window.

Commands arrive on a valid/ready stream. A command holds `cmd_valid` with its direction and rank stable until `cmd_ready` is seen high at a clock edge. The block back-pressures while a window has more than one cycle to run. It also back-pressures while a configuration write is staged but not yet applied. `cmd_ready` does not depend on `cmd_valid`. Configuration uses a plain valid/address/data port with no back-pressure. Written values are staged and only move into the active set when no window is running.

Top module: `odt_mask_driver`

## Requirements
- R1: After reset `odt` is 0, `mask_viol` is 0, `cmd_ready` is 1, both masks are zero and lead and hold are 0. With no window running, `odt` and `mask_viol` are 0.
- R2: A write command to rank R drives `odt` with bits [8R+3:8R] of the write-mask register. Bits [8R+7:8R+4] have no effect on the pins.
- R3: A read command to rank R drives `odt` with bits [4R+3:4R] of the read-mask register, with bit R forced to 0.
- R4: `mask_viol` is 1 for the whole window of a read whose read field has bit R set, and 0 otherwise. Writes never set it.
- R5: `odt` takes the mask in the cycle after the command is accepted. It holds for lead + BURST_LEN + hold cycles, then returns to 0. Lead is timing register bits [1:0] and hold is bits [3:2]; the data burst starts lead cycles into the window.
- R6: A zero field gives a window with `odt` held at 0. The command is still accepted and occupies the window.
- R7: A command accepted in the last cycle of a window changes `odt` straight to its own mask in the next cycle, with no idle cycle between.
- R8: `cmd_ready` is 0 while the running window has more than one cycle left, and 1 in its last cycle when no configuration is staged.
- R9: `cfg_addr` 0 selects the write mask, 1 the read mask, 2 the timing register, and 3 is ignored. A written value is staged and applied only when no window is running, so a window in progress keeps its mask. `cmd_ready` is 0 from the cycle after the write until the value has been applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 write mask, 1 read mask, 2 timing |
| cfg_data | input | 32 | Configuration write data |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted at this edge when high with cmd_valid |
| cmd_write | input | 1 | 1 for a write burst, 0 for a read burst |
| cmd_rank | input | 2 | Target rank |
| odt | output | 4 | Termination pins, one per rank position |
| mask_viol | output | 1 | Read field tried to terminate the rank being read |

## Verification
The assertions check on every cycle the properties that depend on cycle-to-cycle relationships:
- the read target's own pin stays low,
- writes never flag,
- the pins stay frozen inside a window and drop after it unless reloaded,
- back-pressure holds during a window and after a staged configuration write,
- the pins stay quiet when idle.

The mapping from fields to pins for each rank and direction, and the exact window length for every lead and hold pair, can only be shown by the bench sweeps. So can the seamless switch between abutting windows and the rule that a staged value leaves the running window untouched.

// File: rtl/odt_pkg.sv
package odt_pkg;
  typedef enum logic [1:0] {
    SEL_WMASK = 2'd0,
    SEL_RMASK = 2'd1,
    SEL_TIME  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/odt_cfg_regs.sv
module odt_cfg_regs
  import odt_pkg::*;
#(
  parameter int NRANK  = 4,
  parameter int WF     = 8,
  parameter int RF     = 4,
  parameter int TW     = 2,
  parameter int DATA_W = 32,
  localparam int WREG_W = NRANK * WF,
  localparam int RREG_W = NRANK * RF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              win_busy,
  output logic [WREG_W-1:0] wmask_act,
  output logic [RREG_W-1:0] rmask_act,
  output logic [TW-1:0]     lead_act,
  output logic [TW-1:0]     hold_act,
  output logic              pending
);
  logic [WREG_W-1:0] wmask_stg;
  logic [RREG_W-1:0] rmask_stg;
  logic [TW-1:0]     lead_stg, hold_stg;
  logic              wr_hit;
  logic              commit;
  cfg_sel_e          sel;

  assign sel    = cfg_sel_e'(cfg_addr);
  assign wr_hit = cfg_valid && (sel != SEL_NONE);
  assign commit = pending && !win_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wmask_stg <= '0;
      rmask_stg <= '0;
      lead_stg  <= '0;
      hold_stg  <= '0;
    end else if (cfg_valid) begin
      case (sel)
        SEL_WMASK: wmask_stg <= cfg_data[WREG_W-1:0];
        SEL_RMASK: rmask_stg <= cfg_data[RREG_W-1:0];
        SEL_TIME: begin
          lead_stg <= cfg_data[TW-1:0];
          hold_stg <= cfg_data[2*TW-1:TW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (wr_hit) begin
      pending <= 1'b1;
    end else if (commit) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wmask_act <= '0;
      rmask_act <= '0;
      lead_act  <= '0;
      hold_act  <= '0;
    end else if (commit) begin
      wmask_act <= wmask_stg;
      rmask_act <= rmask_stg;
      lead_act  <= lead_stg;
      hold_act  <= hold_stg;
    end
  end
endmodule

// File: rtl/odt_mask_sel.sv
module odt_mask_sel #(
  parameter int NRANK = 4,
  parameter int WF    = 8,
  parameter int RF    = 4,
  localparam int WREG_W = NRANK * WF,
  localparam int RREG_W = NRANK * RF,
  localparam int RANK_W = $clog2(NRANK)
) (
  input  logic [WREG_W-1:0] wmask,
  input  logic [RREG_W-1:0] rmask,
  input  logic              is_write,
  input  logic [RANK_W-1:0] rank,
  output logic [NRANK-1:0]  mask,
  output logic              viol
);
  logic [NRANK-1:0] wfield [NRANK];
  logic [NRANK-1:0] rfield [NRANK];
  logic [NRANK-1:0] own    [NRANK];

  for (genvar g = 0; g < NRANK; g++) begin : g_field
    assign wfield[g] = wmask[g*WF +: NRANK];
    assign rfield[g] = rmask[g*RF +: NRANK];
    assign own[g]    = NRANK'(1) << g;
  end

  logic [NRANK-1:0] wsel, rsel, osel;
  assign wsel = wfield[rank];
  assign rsel = rfield[rank];
  assign osel = own[rank];

  always_comb begin
    if (is_write) begin
      mask = wsel;
      viol = 1'b0;
    end else begin
      mask = rsel & ~osel;
      viol = |(rsel & osel);
    end
  end
endmodule

// File: rtl/odt_window.sv
module odt_window #(
  parameter int NRANK = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CNT_W-1:0] length,
  input  logic [NRANK-1:0] next_mask,
  input  logic             next_viol,
  output logic [NRANK-1:0] odt,
  output logic             viol,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] left;

  assign busy = (left != '0);
  assign last = (left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
      odt  <= '0;
      viol <= 1'b0;
    end else if (fire) begin
      left <= length;
      odt  <= next_mask;
      viol <= next_viol;
    end else if (last) begin
      left <= '0;
      odt  <= '0;
      viol <= 1'b0;
    end else if (busy) begin
      left <= left - CNT_W'(1);
    end
  end
endmodule

// File: rtl/odt_mask_driver.sv
module odt_mask_driver #(
  parameter int NRANK     = 4,
  parameter int WF        = 8,
  parameter int RF        = 4,
  parameter int TW        = 2,
  parameter int BURST_LEN = 4,
  parameter int DATA_W    = 32,
  localparam int RANK_W = $clog2(NRANK),
  localparam int WREG_W = NRANK * WF,
  localparam int RREG_W = NRANK * RF,
  localparam int MAXLEN = 2 * ((1 << TW) - 1) + BURST_LEN,
  localparam int CNT_W  = $clog2(MAXLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [RANK_W-1:0] cmd_rank,
  output logic [NRANK-1:0]  odt,
  output logic              mask_viol
);
  logic [WREG_W-1:0] wmask_act;
  logic [RREG_W-1:0] rmask_act;
  logic [TW-1:0]     lead_act, hold_act;
  logic              pending;
  logic              win_busy, win_last;
  logic [NRANK-1:0]  sel_mask;
  logic              sel_viol;
  logic [CNT_W-1:0]  win_len;
  logic              fire;

  odt_cfg_regs #(
    .NRANK(NRANK), .WF(WF), .RF(RF), .TW(TW), .DATA_W(DATA_W)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .win_busy(win_busy),
    .wmask_act(wmask_act), .rmask_act(rmask_act),
    .lead_act(lead_act), .hold_act(hold_act),
    .pending(pending)
  );

  odt_mask_sel #(
    .NRANK(NRANK), .WF(WF), .RF(RF)
  ) sel_i (
    .wmask(wmask_act), .rmask(rmask_act),
    .is_write(cmd_write), .rank(cmd_rank),
    .mask(sel_mask), .viol(sel_viol)
  );

  assign win_len   = CNT_W'(lead_act) + CNT_W'(BURST_LEN) + CNT_W'(hold_act);
  assign cmd_ready = (!win_busy || win_last) && !pending;
  assign fire      = cmd_valid && cmd_ready;

  odt_window #(
    .NRANK(NRANK), .CNT_W(CNT_W)
  ) win_i (
    .clk(clk), .rst_n(rst_n),
    .fire(fire), .length(win_len),
    .next_mask(sel_mask), .next_viol(sel_viol),
    .odt(odt), .viol(mask_viol),
    .busy(win_busy), .last(win_last)
  );
endmodule

// File: rtl/odt_mask_driver_chk.sv
module odt_mask_driver_chk #(
  parameter int NRANK  = 4,
  localparam int RANK_W = $clog2(NRANK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic [1:0]        cfg_addr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [RANK_W-1:0] cmd_rank,
  input logic [NRANK-1:0]  odt,
  input logic              mask_viol,
  input logic              win_busy,
  input logic              win_last
);
  logic fire_c;
  assign fire_c = cmd_valid && cmd_ready;

  p_read_own_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_c && !cmd_write |=> !odt[$past(cmd_rank)]);

  p_write_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_c && cmd_write |=> !mask_viol);

  p_window_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_busy && !win_last |=> $stable(odt) && $stable(mask_viol));

  p_window_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_last && !fire_c |=> (odt == '0) && !mask_viol);

  p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_busy && !win_last |-> !cmd_ready);

  p_cfg_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && (cfg_addr != 2'd3) |=> !cmd_ready);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !win_busy |-> (odt == '0) && !mask_viol);
endmodule

bind odt_mask_driver odt_mask_driver_chk #(.NRANK(NRANK)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .cmd_rank(cmd_rank),
  .odt(odt), .mask_viol(mask_viol),
  .win_busy(win_busy), .win_last(win_last)
);

// File: tb/odt_mask_driver_tb_top.sv
module odt_mask_driver_tb_top;
  localparam int BL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [1:0]  cmd_rank = '0;
  logic [3:0]  odt;
  logic        mask_viol;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] cur_w, cur_r;
  int          cur_lead, cur_hold;

  always #2 clk = ~clk;

  odt_mask_driver #(.BURST_LEN(BL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_rank(cmd_rank),
    .odt(odt), .mask_viol(mask_viol)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_mask(input bit wr, input int r);
    logic [3:0] f;
    if (wr) return 4'((cur_w >> (8*r)) & 32'hF);
    f = 4'((cur_r >> (4*r)) & 32'hF);
    return f & ~(4'd1 << r);
  endfunction

  function automatic bit exp_viol(input bit wr, input int r);
    if (wr) return 1'b0;
    return cur_r[4*r + r];
  endfunction

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_valid = 1'b0;
    case (a)
      2'd0: cur_w = d;
      2'd1: cur_r = d & 32'hFFFF;
      2'd2: begin cur_lead = int'(d[1:0]); cur_hold = int'(d[3:2]); end
      default: ;
    endcase
  endtask

  // offer a command, wait for acceptance, check the whole window and release
  task automatic run_cmd(input bit wr, input int r, input string req);
    logic [3:0] m;
    bit v;
    int len;
    m = exp_mask(wr, r);
    v = exp_viol(wr, r);
    len = cur_lead + BL + cur_hold;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_rank = 2'(r);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < len; i++) begin
      chk(odt == m, req, odt, m);
      chk(mask_viol == v, "R4", mask_viol, v);
      @(negedge clk);
    end
    chk(odt == 4'd0, "R5 release", odt, 0);
    chk(mask_viol == 1'b0, "R5 release flag", mask_viol, 0);
  endtask

  initial begin
    cur_w = '0; cur_r = '0; cur_lead = 0; cur_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(odt == 4'd0, "R1 odt", odt, 0);
    chk(mask_viol == 1'b0, "R1 viol", mask_viol, 0);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    run_cmd(1'b1, 2, "R1 zero masks");
    run_cmd(1'b0, 1, "R6 zero read");

    // R9 staging blocks ready until applied while idle
    @(negedge clk);
    cfg_valid = 1'b1; cfg_addr = 2'd0; cfg_data = 32'hF3A5_C281;
    @(negedge clk);
    cfg_valid = 1'b0; cur_w = 32'hF3A5_C281;
    chk(cmd_ready == 1'b0, "R9 staged ready", cmd_ready, 0);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 applied ready", cmd_ready, 1);

    // R2/R3/R4 sweep over mask patterns, ranks and directions
    for (int p = 0; p < 3; p++) begin
      logic [31:0] wp, rp;
      wp = (p == 0) ? 32'hF3A5_C281 : (p == 1) ? 32'h1E2D_3C4B : 32'hA0B1_7F08;
      rp = (p == 0) ? 32'h0000_8421 : (p == 1) ? 32'h0000_7BDE : 32'h0000_4218;
      cfg_wr(2'd0, wp);
      cfg_wr(2'd1, rp);
      for (int r = 0; r < 4; r++) begin
        run_cmd(1'b1, r, "R2 write field");
        run_cmd(1'b0, r, "R3 read field");
      end
    end

    // R5/R10 window length over every lead/hold pair
    for (int ld = 0; ld < 4; ld++) begin
      for (int hd = 0; hd < 4; hd++) begin
        cfg_wr(2'd2, 32'(hd * 4 + ld));
        run_cmd(1'b1, (ld + hd) % 4, "R5 window");
      end
    end

    // R6 zero write field for the target rank
    cfg_wr(2'd0, 32'h0F00_FF0F);
    run_cmd(1'b1, 2, "R6 zero write field");

    // R9 address 3 ignored
    cfg_wr(2'd3, 32'hFFFF_FFFF);
    chk(cmd_ready == 1'b1, "R9 addr3 ready", cmd_ready, 1);
    run_cmd(1'b1, 0, "R9 addr3 write");
    run_cmd(1'b0, 3, "R9 addr3 read");

    // R7/R8 abutting windows
    begin
      logic [3:0] ma, mb;
      int la;
      cfg_wr(2'd0, 32'h0804_0201);
      cfg_wr(2'd1, 32'h0000_2481);
      ma = exp_mask(1'b1, 0);
      mb = exp_mask(1'b0, 1);
      la = cur_lead + BL + cur_hold;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_rank = 2'd0;
      @(negedge clk);
      cmd_write = 1'b0; cmd_rank = 2'd1;
      for (int i = 0; i < la; i++) begin
        chk(odt == ma, "R7 first window", odt, ma);
        chk(cmd_ready == (i == la - 1), "R8 ready", cmd_ready, (i == la - 1));
        @(negedge clk);
      end
      cmd_valid = 1'b0;
      for (int i = 0; i < la; i++) begin
        chk(odt == mb, "R7 second window", odt, mb);
        @(negedge clk);
      end
      chk(odt == 4'd0, "R7 release", odt, 0);
    end

    // R9 write staged during a window leaves it untouched
    begin
      logic [3:0] mold, mnew;
      int l2;
      cfg_wr(2'd0, 32'h0000_0006);
      mold = exp_mask(1'b1, 0);
      l2 = cur_lead + BL + cur_hold;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_rank = 2'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      cfg_valid = 1'b1; cfg_addr = 2'd0; cfg_data = 32'h0000_0009;
      @(negedge clk);
      cfg_valid = 1'b0;
      for (int i = 1; i < l2; i++) begin
        chk(odt == mold, "R9 window keeps mask", odt, mold);
        chk(cmd_ready == 1'b0, "R9 ready held", cmd_ready, 0);
        @(negedge clk);
      end
      cur_w = 32'h0000_0009;
      mnew = exp_mask(1'b1, 0);
      chk(mnew == 4'h9, "R9 bench model", mnew, 9);
      run_cmd(1'b1, 0, "R9 new mask applied");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule